// File: doc/BRIEF.md
# Memory-mapped serial port register file

This block is the register-side front end of a serial port controller. A host reaches it through a simple word-addressed bus. Each request is a single-cycle valid strobe with a write flag, a 12-bit byte address and 32-bit data, and read data comes back registered one cycle later. Received characters arrive on a byte-wide input with a ready handshake and land in a 16-entry circular receive queue. Bytes written for transmission leave on a one-cycle strobe. The block also holds the control, line-control, baud-divisor, low-power divisor, trigger-select and DMA-control words. Those words are stored and read back; only two control bits change behaviour here.

One level interrupt comes out of a raw status word, a mask and a write-one-to-clear register. The receive queue has two modes. With the line-control queue bit set it holds 16 entries; with that bit clear it holds one. A line break enters the queue as an 11-bit word that a plain byte can never produce. A small read-only identification window sits at the top of the 4 KB space.

Top module: `uart_regfile`

## Requirements
- R1: After reset the flag word reads 0x90, the control word reads 0x300, the trigger-select word reads 0x12, and every other stored word reads 0. `irq` is low and `rx_ready` is high.
- R2: The register is selected by byte address bits [11:2]. The word indices are: 0 data, 6 flags, 8 low-power divisor, 9 integer divisor, 10 fractional divisor, 11 line control, 12 control, 13 trigger select, 14 mask, 15 raw status, 16 masked status, 17 clear (reads as 0), 18 DMA control. The seven stored configuration words keep the low 16 bits of a write. `bus_rdata` holds the selected value from the cycle after a read request until the next read request.
- R3: `rx_ready` is high while the queue count is below 16 when line-control bit 4 is set, and below 1 when it is clear. A receive word is taken only on a cycle where `rx_ready` is high.
- R4: Data reads return queued entries oldest first, zero-extended to 32 bits. Each new entry goes to the slot at read position plus count, modulo 16.
- R5: When `rx_break` is high on an accepted cycle, the queued word is 0x400 whatever `rx_data` holds.
- R6: Flag word layout: bit 7 transmit-empty (always 1), bit 6 receive-full, bit 5 transmit-full (always 0), bit 4 receive-empty (set exactly when the count is 0). Receive-full is set by a push that brings the count to 16, or by any push while control bit 4 is set. Any data read clears it. Writes to the flag word change nothing.
- R7: A data read while the count is 0 returns the entry at the current read position. It moves neither the position nor the count, so the next pushed word is the next one read.
- R8: A data write drives `tx_data` with the low byte and raises `tx_strobe` for the one following cycle. It also sets raw status bit 5.
- R9: Raw status bit 4 is set by a push that brings the count to 1. It is cleared by a data read that leaves the count at 0.
- R10: A write to the clear word drops every raw bit that is 1 in the written value. A set in the same cycle wins. Masked status is raw AND mask, and `irq` is high exactly when masked status is nonzero.
- R11: Reads at byte addresses 0xFE0 to 0xFFF return one identification byte per word, selected by address bits [4:2], in the order 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Writes there are ignored.
- R12: Unmapped word indices read as 0, and writes to them change no readable state.
- R13: A data read and an accepted push in the same cycle both take effect. The read returns the oldest entry, and the count changes by the net amount. Raw bit 4 is evaluated as the read's clear followed by the push's set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request strobe, one cycle per access |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address in the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte present |
| rx_break | input | 1 | Line break present |
| rx_ready | output | 1 | Queue can take a word this cycle |
| tx_data | output | 8 | Byte to transmit |
| tx_strobe | output | 1 | One-cycle transmit pulse |
| irq | output | 1 | Level interrupt |

## Verification
Read data is due in the cycle after the request edge, and the transmit strobe is due in the cycle after the write edge. `rx_ready`, `irq` and the queue state change at the edge that takes a request or a push. The bench drives every request and receive word on a falling edge so it spans exactly one rising edge. A monitor records at the rising edge that a read was issued. It then compares `bus_rdata` and the transmit pins against queued expectations on the next falling edge, and level outputs are sampled on the falling edge just after the operation's edge.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam int ADDR_W   = 12;
  localparam int DATA_W   = 32;
  localparam int CFG_W    = 16;
  localparam int IRQ_W    = 11;
  localparam int ENTRY_W  = 11;
  localparam int WORD_W   = ADDR_W - 2;
  localparam int NCFG     = 7;
  localparam int RX_TRIG  = 1;
  localparam int RX_IRQ_BIT = 4;
  localparam int TX_IRQ_BIT = 5;

  localparam logic [WORD_W-1:0] IDX_DATA   = 10'd0;
  localparam logic [WORD_W-1:0] IDX_FLAGS  = 10'd6;
  localparam logic [WORD_W-1:0] IDX_MASK   = 10'd14;
  localparam logic [WORD_W-1:0] IDX_RAW    = 10'd15;
  localparam logic [WORD_W-1:0] IDX_MASKED = 10'd16;
  localparam logic [WORD_W-1:0] IDX_CLEAR  = 10'd17;

  localparam int SLOT_LCR  = 3;
  localparam int SLOT_CTRL = 4;
  localparam int FIFO_EN_BIT   = 4;
  localparam int FORCE_FULL_BIT = 4;

  localparam logic [ENTRY_W-1:0] BREAK_WORD = 11'h400;

  // word index of each stored configuration slot
  function automatic logic [WORD_W-1:0] cfg_word(input int slot);
    case (slot)
      0: cfg_word = 10'd8;
      1: cfg_word = 10'd9;
      2: cfg_word = 10'd10;
      3: cfg_word = 10'd11;
      4: cfg_word = 10'd12;
      5: cfg_word = 10'd13;
      default: cfg_word = 10'd18;
    endcase
  endfunction

  function automatic logic [CFG_W-1:0] cfg_init(input int slot);
    case (slot)
      4: cfg_init = 16'h0300;
      5: cfg_init = 16'h0012;
      default: cfg_init = '0;
    endcase
  endfunction

  function automatic logic [7:0] id_byte(input logic [2:0] sel);
    case (sel)
      3'd0: id_byte = 8'h11;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h14;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
  parameter int DEPTH = 16,
  parameter int W     = 11,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [W-1:0]  push_word,
  input  logic          read_req,
  input  logic          deep_mode,
  input  logic          force_full,
  output logic          ready,
  output logic          accepted,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_next,
  output logic          full_flag
);
  logic [PW-1:0] rd_pos, rd_pos_n, wr_pos;
  logic [CW-1:0] cnt_q;
  logic          full_q, full_n, pop;
  logic [W-1:0]  mem [DEPTH];

  assign ready    = cnt_q < (deep_mode ? CW'(DEPTH) : CW'(1));
  assign accepted = push_req && ready;
  assign pop      = read_req && (cnt_q != '0);
  assign wr_pos   = rd_pos + cnt_q[PW-1:0];
  assign head     = mem[rd_pos];
  assign count    = cnt_q;
  assign full_flag = full_q;

  always_comb begin
    count_next = cnt_q + CW'(accepted) - CW'(pop);
    rd_pos_n   = pop ? rd_pos + PW'(1) : rd_pos;
    if (accepted)
      full_n = (count_next == CW'(DEPTH)) || force_full;
    else if (read_req)
      full_n = 1'b0;
    else
      full_n = full_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rd_pos <= '0;
      full_q <= 1'b0;
    end else begin
      cnt_q  <= count_next;
      rd_pos <= rd_pos_n;
      full_q <= full_n;
    end
  end

  // storage array carries no reset
  always_ff @(posedge clk) begin
    if (accepted) mem[wr_pos] <= push_word;
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wdata,
  output logic [W-1:0] raw,
  output logic [W-1:0] mask,
  output logic [W-1:0] masked,
  output logic         irq
);
  logic [W-1:0] raw_n, mask_n;

  always_comb begin
    raw_n  = (raw & ~clr_vec) | set_vec;
    mask_n = mask_we ? mask_wdata : mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw  <= '0;
      mask <= '0;
    end else begin
      raw  <= raw_n;
      mask <= mask_n;
    end
  end

  assign masked = raw & mask;
  assign irq    = |masked;
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_rf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  input  logic              rx_break,
  output logic              rx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_strobe,
  output logic              irq
);
  logic [WORD_W-1:0] word;
  logic in_id, acc_rd, acc_wr, data_rd, data_wr;
  logic [CFG_W-1:0] cfg_q [NCFG];
  logic [CFG_W-1:0] cfg_n [NCFG];
  logic [ENTRY_W-1:0] rx_head, push_word;
  logic [CW-1:0] rx_count, rx_cnt_next;
  logic rx_accepted, rx_full;
  logic [IRQ_W-1:0] set_vec, clr_vec, raw_stat, mask_q, masked;
  logic [7:0] flags;
  logic [DATA_W-1:0] rd_val, rdata_n;
  logic [7:0] tx_data_n;
  logic unused_bits;

  assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:CFG_W]};

  // address decode
  assign word    = bus_addr[ADDR_W-1:2];
  assign in_id   = (bus_addr[ADDR_W-1:5] == '1);
  assign acc_rd  = bus_valid && !bus_write && !in_id;
  assign acc_wr  = bus_valid &&  bus_write && !in_id;
  assign data_rd = acc_rd && (word == IDX_DATA);
  assign data_wr = acc_wr && (word == IDX_DATA);

  // stored configuration words
  always_comb begin
    for (int s = 0; s < NCFG; s++)
      cfg_n[s] = (acc_wr && word == cfg_word(s)) ? bus_wdata[CFG_W-1:0] : cfg_q[s];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NCFG; s++) cfg_q[s] <= cfg_init(s);
    end else begin
      for (int s = 0; s < NCFG; s++) cfg_q[s] <= cfg_n[s];
    end
  end

  // receive queue
  assign push_word = rx_break ? BREAK_WORD : {{(ENTRY_W-8){1'b0}}, rx_data};

  uart_rx_queue #(.DEPTH(DEPTH), .W(ENTRY_W)) u_rxq (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_req   (rx_valid || rx_break),
    .push_word  (push_word),
    .read_req   (data_rd),
    .deep_mode  (cfg_q[SLOT_LCR][FIFO_EN_BIT]),
    .force_full (cfg_q[SLOT_CTRL][FORCE_FULL_BIT]),
    .ready      (rx_ready),
    .accepted   (rx_accepted),
    .head       (rx_head),
    .count      (rx_count),
    .count_next (rx_cnt_next),
    .full_flag  (rx_full)
  );

  // interrupt status
  always_comb begin
    set_vec = '0;
    set_vec[RX_IRQ_BIT] = rx_accepted && (rx_cnt_next == CW'(RX_TRIG));
    set_vec[TX_IRQ_BIT] = data_wr;
    clr_vec = (acc_wr && word == IDX_CLEAR) ? bus_wdata[IRQ_W-1:0] : '0;
    clr_vec[RX_IRQ_BIT] = clr_vec[RX_IRQ_BIT] ||
                          (data_rd && rx_cnt_next == CW'(RX_TRIG - 1));
  end

  uart_irq_ctrl #(.W(IRQ_W)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_vec    (set_vec),
    .clr_vec    (clr_vec),
    .mask_we    (acc_wr && word == IDX_MASK),
    .mask_wdata (bus_wdata[IRQ_W-1:0]),
    .raw        (raw_stat),
    .mask       (mask_q),
    .masked     (masked),
    .irq        (irq)
  );

  // flags: transmit side has no queue, so it is always empty and never full
  assign flags = {1'b1, rx_full, 1'b0, (rx_count == '0), 4'b0000};

  // read mux
  always_comb begin
    rd_val = '0;
    if (in_id) begin
      rd_val[7:0] = id_byte(bus_addr[4:2]);
    end else begin
      if (word == IDX_DATA)   rd_val[ENTRY_W-1:0] = rx_head;
      if (word == IDX_FLAGS)  rd_val[7:0]         = flags;
      if (word == IDX_MASK)   rd_val[IRQ_W-1:0]   = mask_q;
      if (word == IDX_RAW)    rd_val[IRQ_W-1:0]   = raw_stat;
      if (word == IDX_MASKED) rd_val[IRQ_W-1:0]   = masked;
      for (int s = 0; s < NCFG; s++)
        if (word == cfg_word(s)) rd_val[CFG_W-1:0] = cfg_q[s];
    end
    rdata_n   = (bus_valid && !bus_write) ? rd_val : bus_rdata;
    tx_data_n = data_wr ? bus_wdata[7:0] : tx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      tx_data   <= '0;
      tx_strobe <= 1'b0;
    end else begin
      bus_rdata <= rdata_n;
      tx_data   <= tx_data_n;
      tx_strobe <= data_wr;
    end
  end
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk #(
  parameter int DEPTH = 16,
  parameter int IRQ_W = 11,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_valid,
  input logic          bus_write,
  input logic [9:0]    bus_word,
  input logic          rx_ready,
  input logic          tx_strobe,
  input logic          irq,
  input logic [CW-1:0] rx_count,
  input logic [IRQ_W-1:0] raw_stat
);
  // R3: the queue never holds more than its depth
  assert_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(DEPTH));

  // R3: a full queue never offers ready
  assert_ready_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == CW'(DEPTH)) |-> !rx_ready);

  // R13: occupancy moves by at most one per cycle
  assert_step_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == $past(rx_count)) || (rx_count == $past(rx_count) + CW'(1)) ||
    (rx_count == $past(rx_count) - CW'(1)));

  // R8: a transmit pulse always follows a data-word write
  assert_tx_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |-> $past(bus_valid && bus_write && bus_word == 10'd0));

  // R9: leaving the empty state raises the raw receive bit
  assert_rx_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rx_count) == '0 && rx_count != '0) |-> raw_stat[4]);

  // R10: no raw status, no interrupt
  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_stat == '0) |-> !irq);
endmodule

bind uart_regfile uart_regfile_chk #(.DEPTH(DEPTH), .IRQ_W(uart_rf_pkg::IRQ_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_word  (bus_addr[11:2]),
  .rx_ready  (rx_ready),
  .tx_strobe (tx_strobe),
  .irq       (irq),
  .rx_count  (rx_count),
  .raw_stat  (raw_stat)
);

// File: tb/uart_regfile_bench.sv
`timescale 1ns/1ps
module uart_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0, rx_break = 1'b0;
  logic        rx_ready;
  logic [7:0]  tx_data;
  logic        tx_strobe;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic rd_due = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  tx_q[$];
  logic [7:0]  id_seq [8] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  always #2.5 clk = ~clk;

  uart_regfile u_uart_regfile (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // driver tasks: start and end on a falling edge, one cycle each
  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    if (a[11:2] == 0) tx_q.push_back(d[7:0]);
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic bus_rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic rx_push(input logic [7:0] b, input logic brk);
    rx_valid = 1; rx_break = brk; rx_data = b;
    @(negedge clk);
    rx_valid = 0; rx_break = 0;
  endtask

  // monitor: read data due one cycle after the request edge
  always @(posedge clk) rd_due <= bus_valid && !bus_write && rst_n;

  always @(negedge clk) begin
    if (rd_due) begin
      if (exp_q.size() == 0) check("R2 unexpected read data", bus_rdata, 32'hx);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
    if (tx_strobe && rst_n) begin
      if (tx_q.size() == 0) check("R8 unexpected tx strobe", {24'b0, tx_data}, 32'hx);
      else check("R8 tx byte", {24'b0, tx_data}, {24'b0, tx_q.pop_front()});
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1: got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq at reset", {31'b0, irq}, 0);
    check("R1 rx_ready at reset", {31'b0, rx_ready}, 1);
    bus_rd(12'h018, 32'h90, "R1 flags reset");
    bus_rd(12'h030, 32'h300, "R1 control reset");
    bus_rd(12'h034, 32'h12, "R1 trigger select reset");
    bus_rd(12'h02C, 32'h0, "R1 line control reset");
    bus_rd(12'h038, 32'h0, "R1 mask reset");

    // R2 stored words keep low 16 bits
    bus_wr(12'h024, 32'hFFFF1234);
    bus_rd(12'h024, 32'h1234, "R2 integer divisor");
    bus_wr(12'h028, 32'h2A);
    bus_rd(12'h028, 32'h2A, "R2 fractional divisor");
    bus_wr(12'h020, 32'h7);
    bus_rd(12'h020, 32'h7, "R2 low-power divisor");
    bus_wr(12'h048, 32'h3);
    bus_rd(12'h048, 32'h3, "R2 dma control");
    bus_rd(12'h044, 32'h0, "R2 clear word reads zero");

    // R12 unmapped
    bus_wr(12'h01C, 32'hFFFF);
    bus_rd(12'h01C, 32'h0, "R12 unmapped read");
    bus_rd(12'h100, 32'h0, "R12 unmapped far read");
    // R6 flag writes ignored
    bus_wr(12'h018, 32'h0);
    bus_rd(12'h018, 32'h90, "R6 flag write ignored");

    // R11 id window
    for (int i = 0; i < 8; i++)
      bus_rd(12'hFE0 + 12'(4 * i), {24'b0, id_seq[i]}, "R11 id byte");
    bus_wr(12'hFE0, 32'hFF);
    bus_rd(12'hFE0, 32'h11, "R11 id write ignored");

    // R3 single-entry mode
    rx_push(8'h41, 0);
    check("R3 ready low with one entry", {31'b0, rx_ready}, 0);
    bus_rd(12'h03C, 32'h10, "R9 raw rx set");
    bus_rd(12'h018, 32'h80, "R6 not empty");
    rx_push(8'h42, 0);
    bus_rd(12'h000, 32'h41, "R3 second byte refused");
    bus_rd(12'h018, 32'h90, "R6 empty after read");
    bus_rd(12'h03C, 32'h0, "R9 raw rx cleared");
    check("R3 ready back", {31'b0, rx_ready}, 1);

    // R3/R4 16-entry mode
    bus_wr(12'h02C, 32'h10);
    for (int i = 0; i < 16; i++) begin
      check("R3 ready before push", {31'b0, rx_ready}, 1);
      rx_push(8'h60 + 8'(i), 0);
    end
    check("R3 ready low when 16 held", {31'b0, rx_ready}, 0);
    rx_push(8'h99, 0);
    bus_rd(12'h018, 32'hC0, "R6 full flag");
    for (int i = 0; i < 16; i++)
      bus_rd(12'h000, 32'h60 + 32'(i), "R4 queue order");
    bus_rd(12'h018, 32'h90, "R6 empty after drain");

    // R7 empty read
    bus_rd(12'h000, 32'h60, "R7 stale entry");
    bus_rd(12'h018, 32'h90, "R7 still empty");
    rx_push(8'h5A, 0);
    bus_rd(12'h000, 32'h5A, "R7 position unmoved");

    // R5 break
    rx_push(8'h33, 1);
    bus_rd(12'h000, 32'h400, "R5 break word");

    // R8/R10 transmit and interrupt
    bus_wr(12'h000, 32'h1A5);
    bus_rd(12'h03C, 32'h20, "R8 raw tx set");
    check("R10 irq masked off", {31'b0, irq}, 0);
    bus_wr(12'h038, 32'h20);
    check("R10 irq on with mask", {31'b0, irq}, 1);
    bus_rd(12'h040, 32'h20, "R10 masked status");
    bus_wr(12'h044, 32'h20);
    check("R10 irq after clear", {31'b0, irq}, 0);
    bus_rd(12'h03C, 32'h0, "R10 raw after clear");

    // R9 receive interrupt
    bus_wr(12'h038, 32'h10);
    rx_push(8'h11, 0);
    check("R9 irq on push", {31'b0, irq}, 1);
    bus_rd(12'h000, 32'h11, "R9 read data");
    check("R9 irq off after read", {31'b0, irq}, 0);

    // R13 simultaneous read and push
    rx_push(8'hA1, 0);
    rx_valid = 1; rx_data = 8'hB2;
    bus_valid = 1; bus_write = 0; bus_addr = 12'h000;
    exp_q.push_back(32'hA1); tag_q.push_back("R13 read during push");
    @(negedge clk);
    rx_valid = 0; bus_valid = 0;
    bus_rd(12'h03C, 32'h10, "R13 raw rx kept");
    check("R13 irq kept", {31'b0, irq}, 1);
    bus_rd(12'h000, 32'hB2, "R13 pushed word");
    bus_rd(12'h018, 32'h90, "R13 empty after");

    // R6 control bit 4 forces full
    bus_wr(12'h030, 32'h310);
    rx_push(8'h77, 0);
    bus_rd(12'h018, 32'hC0, "R6 forced full");
    bus_rd(12'h000, 32'h77, "R6 forced full data");
    bus_rd(12'h018, 32'h90, "R6 full cleared by read");

    // R8 back-to-back transmit
    bus_wr(12'h000, 32'h55);
    bus_wr(12'h000, 32'h66);

    repeat (3) @(negedge clk);
    check("R2 read queue drained", exp_q.size(), 0);
    check("R8 tx queue drained", tx_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule